// File: doc/BRIEF.md
# Decoupled-Tag Compressed Cache Set

This block holds the bookkeeping for a single set of a second-level cache that stores lines in compressed form. The set carries more tags (four) than it has room for full-size lines (two). Its data area is counted in 8-byte segments, sixteen in total. A compressed line takes anywhere from one to eight segments, and an uncompressed line takes all eight. Because tags outnumber data slots, an entry can stay valid after its payload has been pushed out. A lookup that matches such an entry is reported as a distinct tag-only outcome.

The lookup port compares an address tag against the valid entries. It returns one of three outcomes (data hit, tag-only, or no match) together with the entry's recency position, compression flag, segment size and stored permission bits. The fill port installs or refreshes a line from a tag, a compression flag, a size and permission bits. After a fill, the set walks its recency order from newest to oldest and strips payloads until the segment total fits again. Payload transfer, the compression algorithm and coherence decisions are handled elsewhere.

Top module: `vsc_cache_set`

## Requirements
- R1: After reset no entry is valid, every lookup reports no match, and `seg_used` is 0.
- R2: While `lk_valid` is high, exactly one of the following is asserted:
  - `lk_hit` when a valid entry matches and its data is resident;
  - `lk_tag_only` when a valid entry matches but its data is absent;
  - `lk_miss` when no valid entry matches.

  While `lk_valid` is low, none of the three is asserted.
- R3: On a match, `lk_pos` gives the entry's recency position (0 is most recent, 3 is least recent). `lk_comp` and `lk_size` give its compression flag and size in segments. On no match all three read 0.
- R4: A matching lookup moves that entry to position 0. This applies to both data hits and tag-only results, in a cycle without `fl_valid`. Entries that were more recent move one position older, and the others keep their position.
- R5: A fill whose tag matches no valid entry replaces the entry at position 3. The new tag is installed at position 0 with its data resident.
- R6: A fill whose tag matches a valid entry rewrites that entry's flag, size and permissions in place. The entry moves to position 0 with its data resident, and no other tag is removed.
- R7: A fill with `fl_comp` = 1 (compressed) occupies `fl_size` segments. A fill with `fl_comp` = 0 occupies 8 segments, whatever `fl_size` holds.
- R8: A fill with `fl_comp` = 1 and `fl_size` of 0 or above 8 raises `fl_err` in the same cycle. Such a fill leaves all tags, sizes, residency and positions unchanged.
- R9: After each accepted fill, entries with resident data are visited from position 0 to 3. Each keeps its data while the running segment sum stays at or below 16. The first one that does not fit, and every older one, lose their data but keep a valid tag. `seg_used` always equals the summed size of the resident lines and never exceeds 16.
- R10: When `fl_valid` and `lk_valid` are both high in one cycle, only the fill changes the set state. The lookup outputs still reflect the state before the clock edge.
- R11: On a match, `lk_perm` returns the permission bits stored by the last accepted fill of that tag. On no match it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Lookup address tag |
| lk_hit | output | 1 | Tag matched, data resident |
| lk_tag_only | output | 1 | Tag matched, data absent |
| lk_miss | output | 1 | No valid tag matched |
| lk_pos | output | 2 | Recency position of the match, 0 = newest |
| lk_comp | output | 1 | Compression flag of the match |
| lk_size | output | 4 | Segment count of the match |
| lk_perm | output | PERM_W | Permission bits of the match |
| fl_valid | input | 1 | Fill request |
| fl_tag | input | TAG_W | Fill address tag |
| fl_comp | input | 1 | 1 = line stored compressed |
| fl_size | input | 4 | Compressed size in segments |
| fl_perm | input | PERM_W | Permission bits to store |
| fl_err | output | 1 | Fill rejected for an illegal size |
| seg_used | output | 5 | Segments held by resident lines |

## Verification
The hardest state to reach is a tag-only entry that sits near the newest end of the recency order, behind lines that still hold data. Reaching it takes two steps. First, fills of mixed sizes must squeeze an old line out of the segment budget. Then a lookup must promote that payload-less tag to the front. A following fill then has to strip data from the middle of the order rather than just the tail. The stimulus builds this state on purpose with an uncompressed line followed by three compressed ones. It then runs a long pseudo-random mix over a pool of six tags, which keeps the set saturated and repeatedly promotes tag-only entries. The bench tracks every entry in its own model and queries the ports in every cycle.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  // A fill is accepted when uncompressed, or when its compressed size is 1..smax.
  function automatic logic size_legal(input logic comp, input int unsigned sz,
                                      input int unsigned smax);
    return !comp || (sz >= 1 && sz <= smax);
  endfunction

  // Segments a line really occupies.
  function automatic int unsigned eff_size(input logic comp, input int unsigned sz,
                                           input int unsigned smax);
    return comp ? sz : smax;
  endfunction

  // Does a line of sz segments still fit on top of used?
  function automatic logic seg_fits(input int unsigned used, input int unsigned sz,
                                    input int unsigned budget);
    return (used + sz) <= budget;
  endfunction

endpackage

// File: rtl/vsc_match.sv
module vsc_match #(
  parameter int N     = 4,
  parameter int TAG_W = 12,
  parameter int IW    = 2
) (
  input  logic                      en,
  input  logic [N-1:0]              valid,
  input  logic [N-1:0][TAG_W-1:0]   tags,
  input  logic [TAG_W-1:0]          key,
  output logic [N-1:0]              hit_vec,
  output logic                      any,
  output logic [IW-1:0]             idx
);
  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    assign hit_vec[gi] = en & valid[gi] & (tags[gi] == key);
  end

  always_comb begin
    any = |hit_vec;
    idx = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) idx = IW'(i);
  end
endmodule

// File: rtl/vsc_lru.sv
module vsc_lru #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   touch_en,
  input  logic [IW-1:0]          touch_idx,
  output logic [N-1:0][IW-1:0]   pos_q,
  output logic [N-1:0][IW-1:0]   pos_d,
  output logic [IW-1:0]          lru_idx
);
  always_comb begin
    pos_d = pos_q;
    if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)
          pos_d[i] = '0;
        else if (pos_q[i] < pos_q[touch_idx])
          pos_d[i] = pos_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) pos_q[i] <= IW'(i);
    end else begin
      pos_q <= pos_d;
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++)
      if (pos_q[i] == IW'(N-1)) lru_idx = IW'(i);
  end

  // positions seen across entries, for the permutation check
  logic [N-1:0] pos_seen;
  always_comb begin
    pos_seen = '0;
    for (int i = 0; i < N; i++) pos_seen[pos_q[i]] = 1'b1;
  end

  // R4
  pos_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_seen == {N{1'b1}});

  // R4
  touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> pos_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/vsc_resid.sv
module vsc_resid
  import vsc_pkg::*;
#(
  parameter int N         = 4,
  parameter int IW        = 2,
  parameter int SZ_W      = 4,
  parameter int SUM_W     = 5,
  parameter int SEG_TOTAL = 16
) (
  input  logic [N-1:0]             pres_in,
  input  logic [N-1:0][SZ_W-1:0]   size,
  input  logic [N-1:0][IW-1:0]     pos,
  output logic [N-1:0]             pres_out,
  output logic [SUM_W-1:0]         used
);
  int unsigned sum;
  logic        stop;

  // walk newest to oldest; first line that overflows and all older lose data
  always_comb begin
    sum      = 0;
    stop     = 1'b0;
    pres_out = pres_in;
    for (int p = 0; p < N; p++) begin
      for (int i = 0; i < N; i++) begin
        if (pos[i] == IW'(p) && pres_in[i]) begin
          if (!stop && seg_fits(sum, 32'(size[i]), SEG_TOTAL))
            sum = sum + 32'(size[i]);
          else begin
            stop        = 1'b1;
            pres_out[i] = 1'b0;
          end
        end
      end
    end
    used = SUM_W'(sum);
  end
endmodule

// File: rtl/vsc_cache_set.sv
module vsc_cache_set
  import vsc_pkg::*;
#(
  parameter int N_TAGS    = 4,
  parameter int TAG_W     = 12,
  parameter int PERM_W    = 2,
  parameter int SEG_TOTAL = 16,
  parameter int SEG_MAX   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic                     lk_hit,
  output logic                     lk_tag_only,
  output logic                     lk_miss,
  output logic [1:0]               lk_pos,
  output logic                     lk_comp,
  output logic [3:0]               lk_size,
  output logic [PERM_W-1:0]        lk_perm,
  input  logic                     fl_valid,
  input  logic [TAG_W-1:0]         fl_tag,
  input  logic                     fl_comp,
  input  logic [3:0]               fl_size,
  input  logic [PERM_W-1:0]        fl_perm,
  output logic                     fl_err,
  output logic [4:0]               seg_used
);
  localparam int IW    = $clog2(N_TAGS);
  localparam int SZ_W  = $clog2(SEG_MAX + 1);
  localparam int SUM_W = $clog2(SEG_TOTAL + 1);

  // entry state
  logic [N_TAGS-1:0]               v_q;
  logic [N_TAGS-1:0][TAG_W-1:0]    tag_q;
  logic [N_TAGS-1:0][PERM_W-1:0]   perm_q;
  logic [N_TAGS-1:0]               comp_q;
  logic [N_TAGS-1:0][SZ_W-1:0]     size_q;
  logic [N_TAGS-1:0]               pres_q;

  // named internal events
  logic [N_TAGS-1:0]               lk_hits, fl_hits;
  logic                            lk_any, fl_any;
  logic [IW-1:0]                   lk_idx, fl_idx, lru_idx, victim, touch_idx;
  logic                            fill_ok, touch_en;
  logic [SZ_W-1:0]                 fill_sz;
  logic [N_TAGS-1:0][IW-1:0]       pos_q, pos_d;
  logic [N_TAGS-1:0]               pres_stage, pres_walk;
  logic [N_TAGS-1:0][SZ_W-1:0]     size_stage;
  logic [SUM_W-1:0]                walk_used;

  vsc_match #(.N(N_TAGS), .TAG_W(TAG_W), .IW(IW)) u_lk_match (
    .en(lk_valid), .valid(v_q), .tags(tag_q), .key(lk_tag),
    .hit_vec(lk_hits), .any(lk_any), .idx(lk_idx));

  vsc_match #(.N(N_TAGS), .TAG_W(TAG_W), .IW(IW)) u_fl_match (
    .en(fl_valid), .valid(v_q), .tags(tag_q), .key(fl_tag),
    .hit_vec(fl_hits), .any(fl_any), .idx(fl_idx));

  assign fill_ok   = fl_valid & size_legal(fl_comp, 32'(fl_size), SEG_MAX);
  assign fl_err    = fl_valid & ~fill_ok;
  assign fill_sz   = SZ_W'(eff_size(fl_comp, 32'(fl_size), SEG_MAX));
  assign victim    = fl_any ? fl_idx : lru_idx;
  assign touch_en  = fill_ok | (lk_any & ~fl_valid);
  assign touch_idx = fill_ok ? victim : lk_idx;

  vsc_lru #(.N(N_TAGS), .IW(IW)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .pos_q(pos_q), .pos_d(pos_d), .lru_idx(lru_idx));

  always_comb begin
    pres_stage = pres_q;
    size_stage = size_q;
    if (fill_ok) begin
      pres_stage[victim] = 1'b1;
      size_stage[victim] = fill_sz;
    end
  end

  vsc_resid #(.N(N_TAGS), .IW(IW), .SZ_W(SZ_W), .SUM_W(SUM_W),
              .SEG_TOTAL(SEG_TOTAL)) u_resid (
    .pres_in(pres_stage), .size(size_stage), .pos(pos_d),
    .pres_out(pres_walk), .used(walk_used));

  // lookup outputs
  always_comb begin
    lk_hit      = lk_any & pres_q[lk_idx];
    lk_tag_only = lk_any & ~pres_q[lk_idx];
    lk_miss     = lk_valid & ~lk_any;
    lk_pos      = lk_any ? 2'(pos_q[lk_idx])   : '0;
    lk_comp     = lk_any ? comp_q[lk_idx]      : 1'b0;
    lk_size     = lk_any ? 4'(size_q[lk_idx])  : '0;
    lk_perm     = lk_any ? perm_q[lk_idx]      : '0;
  end

  int unsigned acc;
  always_comb begin
    acc = 0;
    for (int i = 0; i < N_TAGS; i++)
      if (pres_q[i]) acc = acc + 32'(size_q[i]);
    seg_used = 5'(acc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= '0;
      tag_q  <= '0;
      perm_q <= '0;
      comp_q <= '0;
      size_q <= '0;
      pres_q <= '0;
    end else if (fill_ok) begin
      v_q[victim]    <= 1'b1;
      tag_q[victim]  <= fl_tag;
      perm_q[victim] <= fl_perm;
      comp_q[victim] <= fl_comp;
      size_q[victim] <= fill_sz;
      pres_q         <= pres_walk;
    end
  end

  // R2
  lookup_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid ? $onehot({lk_hit, lk_tag_only, lk_miss})
             : ({lk_hit, lk_tag_only, lk_miss} == 3'b000));

  // R9
  seg_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(seg_used) <= SEG_TOTAL && 32'(walk_used) <= SEG_TOTAL);

  // R8
  bad_fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_err |=> $stable(v_q) && $stable(tag_q) && $stable(size_q)
               && $stable(pres_q) && $stable(pos_q));

  // R5
  fill_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |=> v_q[$past(victim)] && pres_q[$past(victim)]
                && pos_q[$past(victim)] == '0);

  // R6
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits) && $onehot0(fl_hits));

  // R10
  lookup_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_ok |=> $stable(v_q) && $stable(tag_q) && $stable(pres_q));
endmodule

// File: tb/sim_vsc_cache_set.sv
`timescale 1ns/1ps
module sim_vsc_cache_set;
  localparam int TAG_W  = 12;
  localparam int PERM_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [TAG_W-1:0] lk_tag = '0;
  logic lk_hit, lk_tag_only, lk_miss, lk_comp, fl_err;
  logic [1:0] lk_pos;
  logic [3:0] lk_size;
  logic [PERM_W-1:0] lk_perm;
  logic fl_valid = 1'b0;
  logic [TAG_W-1:0] fl_tag = '0;
  logic fl_comp = 1'b0;
  logic [3:0] fl_size = '0;
  logic [PERM_W-1:0] fl_perm = '0;
  logic [4:0] seg_used;

  always #2.5 clk = ~clk;

  vsc_cache_set u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .lk_tag_only(lk_tag_only), .lk_miss(lk_miss), .lk_pos(lk_pos),
    .lk_comp(lk_comp), .lk_size(lk_size), .lk_perm(lk_perm),
    .fl_valid(fl_valid), .fl_tag(fl_tag), .fl_comp(fl_comp),
    .fl_size(fl_size), .fl_perm(fl_perm), .fl_err(fl_err),
    .seg_used(seg_used));

  int vectors = 0;
  int errs = 0;

  // reference model
  bit m_valid [4];
  int m_tag   [4];
  int m_perm  [4];
  bit m_comp  [4];
  int m_size  [4];
  bit m_pres  [4];
  int m_pos   [4];

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_valid[i] = 0; m_tag[i] = 0; m_perm[i] = 0; m_comp[i] = 0;
      m_size[i] = 0; m_pres[i] = 0; m_pos[i] = i;
    end
  endtask

  task automatic model_touch(input int v);
    int old;
    old = m_pos[v];
    for (int i = 0; i < 4; i++)
      if (i != v && m_pos[i] < old) m_pos[i]++;
    m_pos[v] = 0;
  endtask

  // ordered budget walk from the newest line
  task automatic model_walk();
    int budget;
    bit full;
    budget = 16;
    full = 0;
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 4; i++)
        if (m_pos[i] == p && m_pres[i]) begin
          if (!full && m_size[i] <= budget) budget -= m_size[i];
          else begin full = 1; m_pres[i] = 0; end
        end
  endtask

  function automatic int model_find(input int t);
    int r;
    r = -1;
    for (int i = 0; i < 4; i++)
      if (m_valid[i] && m_tag[i] == t) r = i;
    return r;
  endfunction

  function automatic int model_used();
    int s;
    s = 0;
    for (int i = 0; i < 4; i++) if (m_pres[i]) s += m_size[i];
    return s;
  endfunction

  task automatic apply(input bit lv, input int lt, input bit fv, input int ft,
                       input bit fc, input int fs, input int fp);
    int mi, fi, v;
    bit ok;
    int ecls;
    @(negedge clk);
    lk_valid = lv; lk_tag = TAG_W'(lt);
    fl_valid = fv; fl_tag = TAG_W'(ft); fl_comp = fc;
    fl_size = 4'(fs); fl_perm = PERM_W'(fp);
    #1;
    mi = lv ? model_find(lt) : -1;
    ecls = !lv ? 0 : (mi < 0 ? 1 : (m_pres[mi] ? 4 : 2));
    chk("R2 class{hit,tagonly,miss}", int'({lk_hit, lk_tag_only, lk_miss}), ecls);
    chk("R3 pos",  int'(lk_pos),  mi >= 0 ? m_pos[mi] : 0);
    chk("R3 comp", int'(lk_comp), mi >= 0 ? int'(m_comp[mi]) : 0);
    chk("R7 size", int'(lk_size), mi >= 0 ? m_size[mi] : 0);
    chk("R11 perm", int'(lk_perm), mi >= 0 ? m_perm[mi] : 0);
    ok = fv && (!fc || (fs >= 1 && fs <= 8));
    chk("R8 fl_err", int'(fl_err), int'(fv && !ok));
    chk("R9 seg_used", int'(seg_used), model_used());
    @(posedge clk);
    if (ok) begin
      fi = model_find(ft);
      v = 0;
      if (fi >= 0) v = fi;
      else for (int i = 0; i < 4; i++) if (m_pos[i] == 3) v = i;
      model_touch(v);
      m_valid[v] = 1; m_tag[v] = ft; m_perm[v] = fp; m_comp[v] = fc;
      m_size[v] = fc ? fs : 8; m_pres[v] = 1;
      model_walk();
    end else if (!fv && mi >= 0) begin
      model_touch(mi);   // R4 promotion on any match
    end
  endtask

  task automatic look(input int t);
    apply(1, t, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input int t, input bit c, input int s, input int p);
    apply(0, 0, 1, t, c, s, p);
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  logic [31:0] rng = 32'h1234_5678;

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk("R1 seg_used after reset", int'(seg_used), 0);
    look(1);
    look(7);
    // R7 uncompressed with size 0 is legal and takes 8
    fill(1, 0, 0, 1);
    look(1);
    fill(2, 1, 2, 2);
    fill(3, 1, 6, 3);
    fill(4, 1, 4, 0);
    // R9 tag 1 now beyond budget: tag-only at the oldest position
    look(1);
    // R4 that lookup promoted it; others shifted
    look(2);
    look(1);
    // R8 illegal compressed sizes
    fill(5, 1, 0, 1);
    fill(5, 1, 9, 1);
    fill(5, 1, 15, 1);
    look(5);
    // R6 refill existing tag with a new size
    fill(3, 1, 3, 2);
    look(3);
    // R5 fill of absent tag evicts the oldest
    fill(5, 1, 8, 3);
    for (int t = 1; t <= 5; t++) look(t);
    // R10 simultaneous lookup and fill
    apply(1, 4, 1, 6, 1, 5, 1);
    for (int t = 1; t <= 6; t++) look(t);
    // sweep
    for (int k = 0; k < 4000; k++) begin
      bit lv, fv, fc;
      int lt, ft, fs, fp;
      rng = rng * 32'd1664525 + 32'd1013904223;
      lv = rng[20];
      fv = rng[21];
      lt = int'(rng[26:23]) % 6;
      ft = int'(rng[30:27]) % 6;
      fc = rng[9] | rng[10];
      fs = rng[15] ? int'(rng[14:11]) : int'(rng[13:11]) + 1;
      fp = int'(rng[17:16]);
      apply(lv, lt, fv, ft, fc, fs, fp);
    end
    @(negedge clk);
    lk_valid = 0; fl_valid = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule